// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. A program counter register addresses an external instruction memory. The returned word is split into its fields and decoded in the same cycle. Both source registers are read before the decode result is known. An ALU, two selection multiplexers and a 32-entry register file then produce the result, which is written at the next rising edge. The core has two memory ports. The instruction port is read-only. The data port carries an address, write data and a write strobe, and both ports expect combinational read data.

The supported set has 21 instructions: word load and store, ten register-register operations, seven immediate operations, branch-if-equal and an absolute jump. The signed add and subtract forms suppress their register write on two's-complement overflow, and the unsigned forms never do. An opcode or function code outside the set completes as a no-op. A synchronous, active-high reset clears the program counter. The register contents are not cleared by reset, so software must initialise them.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, so `imem_addr` reads 0 once reset is released. `dmem_we` stays low while `rst` is high.
- R2: Every instruction other than a taken branch or a jump moves the PC to PC+4. This includes loads, stores, not-taken branches and unrecognised instructions.
- R3: Register-register instructions have op=0x00 and take their operands from rs [25:21] and rt [20:16]. The result is written to rd [15:11]. The function code in [5:0] selects the operation: 0x20 add, 0x21 addu, 0x22 sub, 0x23 subu, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A slt, 0x2B sltu.
- R4: Immediate instructions write their result to rt, with the operand taken from [15:0]. The opcodes are 0x08 addi, 0x09 addiu, 0x0A slti, 0x0B sltiu, 0x0C andi, 0x0D ori and 0x0E xori. andi, ori and xori zero-extend the immediate, and the other immediate instructions sign-extend it.
- R5: slt and slti compare as signed numbers and write 1 or 0. sltu and sltiu compare as unsigned numbers. sltiu compares against its sign-extended immediate.
- R6: When add, sub or addi overflows in two's complement, the destination register keeps its old value. addu, subu and addiu always write the wrapped result.
- R7: Register 0 always reads as zero, and any write aimed at it is dropped.
- R8: lw (0x23) and sw (0x2B) use the address rs + sign-extended [15:0]. lw writes the `dmem_rdata` word to rt. sw drives `dmem_addr` to that address, drives `dmem_wdata` to the value of rt, and raises `dmem_we` for that cycle.
- R9: beq (0x04) compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended [15:0] shifted left by two. Otherwise the next PC is PC+4.
- R10: j (0x02) loads the PC with bits [31:28] of PC+4, followed by [25:0], followed by two zero bits.
- R11: An unrecognised opcode, or an op=0x00 word with a function code not listed in R3, writes no register and no memory.
- R12: `dmem_we` is high only during a cycle that executes sw.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address of a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
The bench targets the overflow boundaries: 0x7FFFFFFF+1, 0x80000000-1 and addi on the largest positive value. A core that writes the wrapped value anyway, or that suppresses the unsigned forms as well, leaves the wrong value in the destination register. It also contrasts signed and unsigned compares on 0x80000000 and compares sltiu against an immediate of 0xFFFF. A core that picks the wrong extension or the wrong signedness stores a flipped 0/1 flag. The remaining corner cases are writes to register 0, negative load/store offsets, taken and not-taken branches, forward jumps and unrecognised words. A core that gets any of these wrong either stores a nonzero value for register 0, takes the wrong fetch path (the per-cycle PC check catches this), or raises a spurious store strobe. Each program ends by storing every register to memory, so any corrupted register shows up as a store-data mismatch.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU
  } alu_op_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef struct packed {
    alu_op_e alu_op;
    logic    b_imm;      // second ALU operand from immediate
    logic    imm_zext;   // zero- rather than sign-extend
    logic    reg_we;
    logic    dst_rt;     // destination is rt rather than rd
    logic    mem_to_reg;
    logic    mem_we;
    logic    branch;
    logic    jump;
    logic    ovf_trap;   // suppress write on signed overflow
  } ctrl_t;
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr_a,
  input  logic [RA_W-1:0]   raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              zero,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff;
  logic              lt_s, lt_u;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = sum;
      ALU_SUB:  y = diff;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{MSB{1'b0}}, lt_s};
      default:  y = {{MSB{1'b0}}, lt_u};
    endcase
  end

  always_comb begin
    case (op)
      ALU_ADD: ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      ALU_SUB: ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
      default: ovf = 1'b0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        ctl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  begin ctl.alu_op = ALU_ADD;  ctl.ovf_trap = 1'b1; end
          FN_ADDU: ctl.alu_op = ALU_ADD;
          FN_SUB:  begin ctl.alu_op = ALU_SUB;  ctl.ovf_trap = 1'b1; end
          FN_SUBU: ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_XOR:  ctl.alu_op = ALU_XOR;
          FN_NOR:  ctl.alu_op = ALU_NOR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          FN_SLTU: ctl.alu_op = ALU_SLTU;
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI:  begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.ovf_trap = 1'b1; end
      OP_ADDIU: begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1; end
      OP_SLTI:  begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.alu_op = ALU_SLT; end
      OP_SLTIU: begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.alu_op = ALU_SLTU; end
      OP_ANDI:  begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.imm_zext = 1'b1; ctl.alu_op = ALU_AND; end
      OP_ORI:   begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.imm_zext = 1'b1; ctl.alu_op = ALU_OR; end
      OP_XORI:  begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.imm_zext = 1'b1; ctl.alu_op = ALU_XOR; end
      OP_LW:    begin ctl.reg_we = 1'b1; ctl.dst_rt = 1'b1; ctl.b_imm = 1'b1;
                      ctl.mem_to_reg = 1'b1; end
      OP_SW:    begin ctl.b_imm = 1'b1; ctl.mem_we = 1'b1; end
      OP_BEQ:   begin ctl.branch = 1'b1; ctl.alu_op = ALU_SUB; end
      OP_J:     ctl.jump = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [DATA_W-1:0] imem_rdata,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_we,
  input  logic [DATA_W-1:0] dmem_rdata
);
  localparam int RA_W  = $clog2(NREG);
  localparam int IMM_W = 16;
  localparam int TGT_W = 26;

  logic [DATA_W-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
  logic [DATA_W-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
  logic [5:0]        op, funct;
  logic [RA_W-1:0]   rs, rt, rd, waddr;
  logic [IMM_W-1:0]  imm;
  logic              alu_zero, alu_ovf, rf_we, br_taken;
  ctrl_t             ctl;

  assign instr = imem_rdata;
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign imm   = instr[15:0];

  sc_decode u_decode (.op(op), .funct(funct), .ctl(ctl));

  // both sources fetched before the instruction class is known
  sc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regfile (
    .clk(clk), .we(rf_we), .waddr(waddr), .wdata(wb_data),
    .raddr_a(rs), .raddr_b(rt), .rdata_a(rs_val), .rdata_b(rt_val)
  );

  assign imm_ext = ctl.imm_zext ? {{(DATA_W-IMM_W){1'b0}}, imm}
                                : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign alu_b   = ctl.b_imm ? imm_ext : rt_val;

  sc_alu #(.DATA_W(DATA_W)) u_alu (
    .op(ctl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero), .ovf(alu_ovf)
  );

  assign wb_data = ctl.mem_to_reg ? dmem_rdata : alu_y;
  assign waddr   = ctl.dst_rt ? rt : rd;
  assign rf_we   = !rst && ctl.reg_we && !(ctl.ovf_trap && alu_ovf);

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = !rst && ctl.mem_we;

  assign pc_plus4   = pc + DATA_W'(4);
  assign br_target  = pc_plus4 + {imm_ext[DATA_W-3:0], 2'b00};
  assign jmp_target = {pc_plus4[DATA_W-1:TGT_W+2], instr[TGT_W-1:0], 2'b00};
  assign br_taken   = ctl.branch && alu_zero;

  always_comb begin
    if (ctl.jump)      pc_next = jmp_target;
    else if (br_taken) pc_next = br_target;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC[DATA_W-1:0];
    else     pc <= pc_next;
  end

  assign imem_addr = pc;

  AST_RESET_PC: assert property (@(posedge clk)
    rst |=> imem_addr == RESET_PC[DATA_W-1:0]); // R1
  AST_RESET_NO_STORE: assert property (@(posedge clk)
    rst |-> !dmem_we); // R1
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !ctl.branch) |=> imem_addr == $past(imem_addr) + DATA_W'(4)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ctl.ovf_trap && alu_ovf) |-> !rf_we); // R6
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rs == '0) |-> rs_val == '0); // R7
  AST_BEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && rs_val != rt_val) |=> imem_addr == $past(imem_addr) + DATA_W'(4)); // R9
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> imem_addr[TGT_W+1:0] == {$past(imem_rdata[TGT_W-1:0]), 2'b00}); // R10
  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == OP_SW); // R12
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] rmem [256];
  logic [31:0] rr   [32];
  logic [31:0] rpc;
  string       ptag;
  int          n_chk = 0, n_bad = 0;
  bit          halted;

  always #5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (pc %h)", tag, act, exp, rpc);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int d, input int s, input int t);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] o, input int t, input int s, input logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction
  function automatic logic [31:0] enc_j(input int word);
    return {6'h02, 26'(word)};
  endfunction

  // reference model: one instruction per call, checks then commits
  task automatic ref_step();
    logic [31:0] ins, a, b, sx, zx, nxt, res, ea;
    logic [5:0]  o, fn;
    int          s, t, d;
    bit          st, wr;
    longint      wide;
    int          dst;
    string       ntag;
    ins = imem[rpc[9:2]];
    o = ins[31:26]; fn = ins[5:0];
    s = int'(ins[25:21]); t = int'(ins[20:16]); d = int'(ins[15:11]);
    a = rr[s]; b = rr[t];
    sx = {{16{ins[15]}}, ins[15:0]}; zx = {16'h0, ins[15:0]};
    nxt = rpc + 4; st = 0; wr = 0; res = 0; dst = t; ea = a + sx; ntag = "R2";
    check(imem_addr === rpc, ptag, imem_addr, rpc);
    halted = (ins == enc_j(int'(rpc[27:2])));
    if (o == 6'h00) begin
      dst = d; wr = 1;
      case (fn)
        6'h20: begin wide = longint'($signed(a)) + longint'($signed(b)); res = a + b;
                     wr = (wide >= -64'sd2147483648 && wide <= 64'sd2147483647); end
        6'h21: res = a + b;
        6'h22: begin wide = longint'($signed(a)) - longint'($signed(b)); res = a - b;
                     wr = (wide >= -64'sd2147483648 && wide <= 64'sd2147483647); end
        6'h23: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h26: res = a ^ b;
        6'h27: res = ~(a | b);
        6'h2A: res = ($signed(a) < $signed(b)) ? 1 : 0;
        6'h2B: res = (a < b) ? 1 : 0;
        default: begin wr = 0; ntag = "R11"; end
      endcase
    end else begin
      wr = 1;
      case (o)
        6'h08: begin wide = longint'($signed(a)) + longint'($signed(sx)); res = a + sx;
                     wr = (wide >= -64'sd2147483648 && wide <= 64'sd2147483647); end
        6'h09: res = a + sx;
        6'h0A: res = ($signed(a) < $signed(sx)) ? 1 : 0;
        6'h0B: res = (a < sx) ? 1 : 0;
        6'h0C: res = a & zx;
        6'h0D: res = a | zx;
        6'h0E: res = a ^ zx;
        6'h23: res = rmem[ea[9:2]];
        6'h2B: begin wr = 0; st = 1; end
        6'h04: begin wr = 0; ntag = "R9"; if (a == b) nxt = rpc + 4 + {sx[29:0], 2'b00}; end
        6'h02: begin wr = 0; ntag = "R10"; nxt = {nxt[31:28], ins[25:0], 2'b00}; end
        default: begin wr = 0; ntag = "R11"; end
      endcase
    end
    check(dmem_we === st, "R12 store strobe", 32'(dmem_we), 32'(st));
    if (st) begin
      check(dmem_addr === ea, "R8 store address", dmem_addr, ea);
      if (ea >= 32'h200)
        check(dmem_wdata === b, "R3/R4/R5/R6/R7/R11 register dump", dmem_wdata, b);
      else
        check(dmem_wdata === b, "R8 store data", dmem_wdata, b);
      rmem[ea[9:2]] = b;
      dmem[dmem_addr[9:2]] = dmem_wdata;
    end
    if (wr && dst != 0) rr[dst] = res;
    rpc = nxt; ptag = ntag;
  endtask

  function automatic logic [31:0] rand_ins(input int idx, input int len);
    int k, s, t, d;
    logic [15:0] im;
    k = $urandom_range(0, 23);
    s = $urandom_range(0, 31); t = $urandom_range(0, 31); d = $urandom_range(0, 31);
    case ($urandom_range(0, 3))
      0: im = 16'h7FFF;
      1: im = 16'h8000;
      2: im = 16'hFFFF;
      default: im = 16'($urandom);
    endcase
    if (k <= 9) begin
      logic [5:0] fl [10] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B};
      return enc_r(fl[k], d, s, t);
    end
    if (k <= 16) return enc_i(6'(k - 10 + 8), t, s, im);
    if (k == 17 || k == 23) return enc_i(6'h23, t, 0, 16'($urandom_range(0, 127) * 4));
    if (k == 18) return enc_i(6'h2B, t, 0, 16'($urandom_range(0, 127) * 4));
    if (k == 19 && idx < len - 4)
      return enc_i(6'h04, ($urandom_range(0, 1) != 0) ? s : t, s, 16'($urandom_range(0, 3)));
    if (k == 20 && idx < len - 4) return enc_j(idx + 1 + $urandom_range(0, 3));
    if (k == 21) return {6'h3F, 26'($urandom)};
    if (k == 22) return enc_r(6'h00, d, s, t);
    return enc_r(6'h21, d, s, t);
  endfunction

  task automatic load_prog(input bit directed);
    int p;
    for (int i = 0; i < 256; i++) begin
      imem[i] = '0;
      dmem[i] = $urandom;
    end
    dmem[0] = 32'h7FFF_FFFF; dmem[1] = 32'h8000_0000;
    for (int i = 0; i < 256; i++) rmem[i] = dmem[i];
    p = 0;
    for (int k = 1; k < 32; k++) begin imem[p] = enc_r(6'h21, k, 0, 0); p++; end
    if (directed) begin
      imem[p] = enc_i(6'h23, 1, 0, 16'h0000); p++;   // 0x7FFFFFFF
      imem[p] = enc_i(6'h23, 2, 0, 16'h0004); p++;   // 0x80000000
      imem[p] = enc_i(6'h09, 3, 0, 16'h0001); p++;
      imem[p] = enc_i(6'h09, 4, 0, 16'h0055); p++;
      imem[p] = enc_r(6'h20, 4, 1, 3); p++;          // R6 overflow, r4 kept
      imem[p] = enc_r(6'h21, 5, 1, 3); p++;          // R6 unsigned wraps
      imem[p] = enc_r(6'h22, 6, 2, 3); p++;          // R6 sub overflow
      imem[p] = enc_i(6'h08, 7, 1, 16'h0001); p++;   // R6 addi overflow
      imem[p] = enc_r(6'h2A, 8, 2, 1); p++;          // R5 signed
      imem[p] = enc_r(6'h2B, 9, 2, 1); p++;          // R5 unsigned
      imem[p] = enc_i(6'h0A, 10, 2, 16'hFFFF); p++;
      imem[p] = enc_i(6'h0B, 11, 3, 16'hFFFF); p++;
      imem[p] = enc_i(6'h0D, 12, 0, 16'h8000); p++;  // R4 zero-extended
      imem[p] = enc_i(6'h09, 13, 0, 16'h8000); p++;  // R4 sign-extended
      imem[p] = enc_i(6'h09, 0, 0, 16'h0005); p++;   // R7 write to r0
      imem[p] = enc_r(6'h27, 0, 1, 2); p++;
      imem[p] = enc_i(6'h2B, 0, 0, 16'h0008); p++;   // R7 stores zero
      imem[p] = enc_i(6'h04, 3, 3, 16'h0001); p++;   // R9 taken
      imem[p] = enc_i(6'h09, 14, 0, 16'h0BAD); p++;  // skipped
      imem[p] = enc_i(6'h04, 2, 1, 16'h0003); p++;   // R9 not taken
      imem[p] = enc_j(p + 2); p++;                   // R10
      imem[p] = enc_i(6'h09, 15, 0, 16'h0BAD); p++;  // skipped
      imem[p] = {6'h3F, 26'h3FFFFFF}; p++;           // R11
      imem[p] = enc_r(6'h00, 16, 1, 2); p++;         // R11 unlisted funct
      imem[p] = enc_i(6'h2B, 1, 0, 16'h0010); p++;
      imem[p] = enc_i(6'h09, 17, 0, 16'h0020); p++;
      imem[p] = enc_i(6'h2B, 2, 17, 16'hFFFC); p++;  // R8 negative offset
      imem[p] = enc_i(6'h23, 18, 17, 16'hFFFC); p++;
      imem[p] = enc_i(6'h23, 0, 0, 16'h0000); p++;   // R7 load to r0
    end else begin
      for (int i = 0; i < 150; i++) begin imem[p] = rand_ins(p, 31 + 150); p++; end
    end
    for (int k = 1; k < 32; k++) begin imem[p] = enc_i(6'h2B, k, 0, 16'(32'h200 + 4 * k)); p++; end
    imem[p] = enc_j(p);
  endtask

  task automatic run_prog(input bit directed);
    int guard;
    rst = 1'b1;
    load_prog(directed);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(dmem_we === 1'b0, "R1 no store in reset", 32'(dmem_we), 32'h0);
    rst = 1'b0;
    #1;
    rpc = 32'h0; ptag = "R1"; halted = 0; guard = 0;
    while (!halted && guard < 2000) begin
      ref_step();
      guard++;
      if (!halted) @(negedge clk);
    end
    check(halted, "R2 program reached its end", 32'(guard), 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) rr[i] = '0;
    run_prog(1'b1);
    for (int n = 0; n < 4; n++) run_prog(1'b0);
    run_prog(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule